// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block behaves as the slave side of a small three-wire serial EEPROM. The block samples a chip-select line, a serial clock and a serial data input on the system clock. Each command starts with a start bit, followed by a two-bit opcode and a six-bit address field. The block decodes the command and acts on a register-based memory of 16 words of 16 bits. Read data and the ready/busy indication leave on one serial output.

Programming commands (write, erase, fill with one pattern, erase everything) are guarded by an enable latch. The host sets and clears this latch with two dedicated commands. Programming is self-timed: it starts when chip select drops after the final bit of the command, and a parameterized cycle counter models its length. While the cycle runs, the host can raise chip select and watch the serial output to see when the device is ready again.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset, ser_out is 0, the enable latch is clear and every word reads 16'hFFFF.
- R2: While chip_sel is high, bits are taken from ser_in on each rising ser_clk edge. Leading 0 bits are skipped until a start bit of 1 arrives. The start bit is followed by a 2-bit opcode and a 6-bit field, most significant bit first.
- R3: Opcode 2'b10 means read, 2'b01 means write and 2'b11 means erase, and field bits [3:0] select the word for these three. Opcode 2'b00 is decoded by field bits [5:4]: 2'b11 sets the enable latch, 2'b00 clears it, 2'b10 erases all words and 2'b01 writes all words. Field bits [3:0] are ignored for opcode 2'b00.
- R4: On a read, ser_out becomes a dummy 0 at the rising ser_clk edge that carries the last field bit. Each following rising edge then presents one data bit, D15 first. While chip_sel is high, ser_out changes only at rising ser_clk edges.
- R5: Only the set command sets the enable latch. Only the clear command or reset clears it. Reads work whatever the latch holds.
- R6: Erase makes the addressed word 16'hFFFF and leaves the other words unchanged. Erase-all makes every word 16'hFFFF.
- R7: Write and write-all take 16 data bits, D15 first, after the field. Write stores them in the addressed word, and write-all stores them in every word.
- R8: A programming cycle starts on the chip_sel fall that follows the final command bit. It stays busy for exactly PROG_CYCLES clocks and updates the memory when it ends.
- R9: Once a cycle has started and chip_sel is high again, ser_out is 0 while busy and 1 once ready. This status display ends when the next start bit is accepted.
- R10: A programming command received while the enable latch is clear changes no word and starts no busy period.
- R11: chip_sel low at any point abandons a partly shifted command. A write cut short of 16 data bits changes nothing.
- R12: Start bits that arrive while busy are ignored, and ser_out keeps showing status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_sel | input | 1 | Chip select, active high |
| ser_clk | input | 1 | Serial clock from the host |
| ser_in | input | 1 | Serial command and data input |
| ser_out | output | 1 | Serial read data or ready/busy status |

## Verification
The bench keeps the default geometry of 16 words of 16 bits, so a sweep can write and read back every address with its own pattern. It lowers PROG_CYCLES to 40. That is short enough to run many programming cycles, and still longer than a full 9-bit command header sent while busy, so the test of ignored start bits fits inside one busy window. The busy length is measured to the exact clock against PROG_CYCLES.

// File: rtl/see_pkg.sv
package see_pkg;

  typedef enum logic [2:0] {
    CMD_READ, CMD_WRITE, CMD_ERASE, CMD_WEN, CMD_WDS, CMD_ERAL, CMD_WRAL
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_DATA, ST_READ, ST_ARMED, ST_DONE
  } state_e;

  // Opcode 00 is split further by the two top field bits.
  function automatic cmd_e decode_cmd(input logic [1:0] op, input logic [1:0] sel);
    cmd_e c;
    case (op)
      2'b10:   c = CMD_READ;
      2'b01:   c = CMD_WRITE;
      2'b11:   c = CMD_ERASE;
      default: begin
        case (sel)
          2'b11:   c = CMD_WEN;
          2'b10:   c = CMD_ERAL;
          2'b01:   c = CMD_WRAL;
          default: c = CMD_WDS;
        endcase
      end
    endcase
    return c;
  endfunction

  function automatic logic needs_data(input cmd_e c);
    return (c == CMD_WRITE) || (c == CMD_WRAL);
  endfunction

endpackage

// File: rtl/see_pin_edges.sv
module see_pin_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic sk,
  input  logic cs,
  output logic sk_rise,
  output logic cs_fall
);
  logic sk_q, cs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sk_q <= 1'b0;
      cs_q <= 1'b0;
    end else begin
      sk_q <= sk;
      cs_q <= cs;
    end
  end

  assign sk_rise = sk & ~sk_q;
  assign cs_fall = cs_q & ~cs;
endmodule

// File: rtl/see_cmd_fsm.sv
module see_cmd_fsm import see_pkg::*; #(
  parameter int WORD_W  = 16,
  parameter int ADDR_W  = 4,
  parameter int FIELD_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              di,
  input  logic              sk_rise,
  input  logic              cs_fall,
  input  logic              busy,
  input  logic [WORD_W-1:0] rd_word,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              accept,
  output logic              set_wen,
  output logic              clr_wen,
  output logic              prog_req,
  output cmd_e              cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] data_o,
  output logic              idle,
  output logic              dout
);
  localparam int HDR_LEN = 2 + FIELD_W;
  localparam int MAXB    = (HDR_LEN > WORD_W) ? HDR_LEN : WORD_W;
  localparam int CNT_W   = $clog2(MAXB) + 1;

  state_e            state;
  logic [CNT_W-1:0]  cnt;
  logic [HDR_LEN-1:0] hdr;
  logic [HDR_LEN-1:0] hdr_nxt;
  logic [WORD_W-1:0] shreg;
  logic              hdr_last;
  cmd_e              cmd_now;

  assign hdr_nxt  = {hdr[HDR_LEN-2:0], di};
  assign hdr_last = (state == ST_HDR) && sk_rise && (cnt == CNT_W'(HDR_LEN-1));
  assign cmd_now  = decode_cmd(hdr_nxt[HDR_LEN-1 -: 2], hdr_nxt[FIELD_W-1 -: 2]);
  assign rd_addr  = hdr_nxt[ADDR_W-1:0];
  assign accept   = (state == ST_IDLE) && cs && sk_rise && di && !busy;
  assign set_wen  = hdr_last && (cmd_now == CMD_WEN);
  assign clr_wen  = hdr_last && (cmd_now == CMD_WDS);
  assign prog_req = (state == ST_ARMED) && cs_fall;
  assign idle     = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      hdr    <= '0;
      shreg  <= '0;
      dout   <= 1'b0;
      cmd_o  <= CMD_WDS;
      addr_o <= '0;
      data_o <= '0;
    end else if (!cs) begin
      state <= ST_IDLE;
      cnt   <= '0;
      dout  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state <= ST_HDR;
          cnt   <= '0;
        end
        ST_HDR: if (sk_rise) begin
          hdr <= hdr_nxt;
          cnt <= cnt + 1'b1;
          if (hdr_last) begin
            cmd_o  <= cmd_now;
            addr_o <= hdr_nxt[ADDR_W-1:0];
            cnt    <= '0;
            if (cmd_now == CMD_READ) begin
              state <= ST_READ;
              shreg <= rd_word;
              dout  <= 1'b0;
            end else if (needs_data(cmd_now)) begin
              state <= ST_DATA;
            end else if (cmd_now == CMD_ERASE || cmd_now == CMD_ERAL) begin
              state <= ST_ARMED;
            end else begin
              state <= ST_DONE;
            end
          end
        end
        ST_DATA: if (sk_rise) begin
          data_o <= {data_o[WORD_W-2:0], di};
          cnt    <= cnt + 1'b1;
          if (cnt == CNT_W'(WORD_W-1)) state <= ST_ARMED;
        end
        ST_READ: if (sk_rise) begin
          dout  <= shreg[WORD_W-1];
          shreg <= {shreg[WORD_W-2:0], 1'b0};
        end
        default: ;
      endcase
    end
  end

  assert_cs_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> (state == ST_IDLE));
  assert_dout_on_edges_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !sk_rise) |=> $stable(dout));
endmodule

// File: rtl/see_prog_engine.sv
module see_prog_engine import see_pkg::*; #(
  parameter int WORD_W      = 16,
  parameter int ADDR_W      = 4,
  parameter int PROG_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_wen,
  input  logic              clr_wen,
  input  logic              prog_req,
  input  cmd_e              cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word,
  output logic              busy,
  output logic              go
);
  localparam int WORDS = 1 << ADDR_W;
  localparam int TW    = $clog2(PROG_CYCLES + 1);

  logic              wen;
  logic [TW-1:0]     tcnt;
  cmd_e              p_cmd;
  logic [ADDR_W-1:0] p_addr;
  logic [WORD_W-1:0] p_data;
  logic              commit;
  logic [WORDS*WORD_W-1:0] flat;

  function automatic logic [WORD_W-1:0] next_word(
    input cmd_e c, input logic hit,
    input logic [WORD_W-1:0] old, input logic [WORD_W-1:0] d);
    case (c)
      CMD_ERASE: return hit ? '1 : old;
      CMD_WRITE: return hit ? d  : old;
      CMD_ERAL:  return '1;
      CMD_WRAL:  return d;
      default:   return old;
    endcase
  endfunction

  assign go     = prog_req && wen && !busy;
  assign commit = busy && (tcnt == TW'(PROG_CYCLES-1));

  always_ff @(posedge clk) begin
    if (!rst_n)       wen <= 1'b0;
    else if (set_wen) wen <= 1'b1;
    else if (clr_wen) wen <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      tcnt   <= '0;
      p_cmd  <= CMD_WDS;
      p_addr <= '0;
      p_data <= '0;
    end else if (go) begin
      busy   <= 1'b1;
      tcnt   <= '0;
      p_cmd  <= cmd;
      p_addr <= addr;
      p_data <= data;
    end else if (busy) begin
      tcnt <= tcnt + 1'b1;
      if (commit) busy <= 1'b0;
    end
  end

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)      q <= '1;
      else if (commit) q <= next_word(p_cmd, p_addr == ADDR_W'(i), q, p_data);
    end
    assign flat[i*WORD_W +: WORD_W] = q;
  end

  assign rd_word = flat[int'(rd_addr)*WORD_W +: WORD_W];

  assert_go_then_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);
  assert_mem_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(flat));
  assert_wen_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wen) |-> $past(set_wen));
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave import see_pkg::*; #(
  parameter int WORD_W      = 16,
  parameter int ADDR_W      = 4,
  parameter int FIELD_W     = 6,
  parameter int PROG_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_sel,
  input  logic ser_clk,
  input  logic ser_in,
  output logic ser_out
);
  logic              sk_rise, cs_fall;
  logic              accept, set_wen, clr_wen, prog_req, idle, fsm_dout;
  logic              busy, go, stat_flag;
  logic [ADDR_W-1:0] rd_addr, addr;
  logic [WORD_W-1:0] rd_word, data;
  cmd_e              cmd;

  see_pin_edges u_edges (
    .clk(clk), .rst_n(rst_n), .sk(ser_clk), .cs(chip_sel),
    .sk_rise(sk_rise), .cs_fall(cs_fall)
  );

  see_cmd_fsm #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cs(chip_sel), .di(ser_in),
    .sk_rise(sk_rise), .cs_fall(cs_fall), .busy(busy), .rd_word(rd_word),
    .rd_addr(rd_addr), .accept(accept), .set_wen(set_wen), .clr_wen(clr_wen),
    .prog_req(prog_req), .cmd_o(cmd), .addr_o(addr), .data_o(data),
    .idle(idle), .dout(fsm_dout)
  );

  see_prog_engine #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_eng (
    .clk(clk), .rst_n(rst_n), .set_wen(set_wen), .clr_wen(clr_wen),
    .prog_req(prog_req), .cmd(cmd), .addr(addr), .data(data),
    .rd_addr(rd_addr), .rd_word(rd_word), .busy(busy), .go(go)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      stat_flag <= 1'b0;
    else if (go)     stat_flag <= 1'b1;
    else if (accept) stat_flag <= 1'b0;
  end

  assign ser_out = !chip_sel ? 1'b0 :
                   (idle && stat_flag) ? ~busy : fsm_dout;

  assert_busy_after_cs_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!chip_sel));
endmodule

// File: tb/serial_eeprom_slave_test.sv
module serial_eeprom_slave_test;
  localparam int PROG = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_o;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;
  logic [15:0] model [16];

  always #2.5 clk = ~clk;

  serial_eeprom_slave #(.PROG_CYCLES(PROG)) uut (
    .clk(clk), .rst_n(rst_n), .chip_sel(cs), .ser_clk(sk), .ser_in(di), .ser_out(do_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sk_bit(input logic b, output logic s);
    @(negedge clk); di = b; sk = 1'b0;
    @(negedge clk); sk = 1'b1;
    @(negedge clk); s = do_o;
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [5:0] f, output logic last);
    logic s;
    sk_bit(1'b1, s);
    for (int k = 1; k >= 0; k--) sk_bit(op[k], s);
    for (int k = 5; k >= 0; k--) sk_bit(f[k], s);
    last = s;
  endtask

  task automatic cs_up();
    @(negedge clk); cs = 1'b1; sk = 1'b0;
  endtask

  task automatic cs_down();
    @(negedge clk); cs = 1'b0; sk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic read_word(input logic [3:0] a, input int lead, output logic [15:0] w);
    logic s, d;
    cs_up();
    for (int k = 0; k < lead; k++) sk_bit(1'b0, s);
    send_hdr(2'b10, {2'b00, a}, d);
    check(d == 1'b0, "R4 dummy bit", {31'd0, d}, 32'd0);
    w = '0;
    for (int k = 0; k < 16; k++) begin
      sk_bit(1'b0, s);
      w = {w[14:0], s};
    end
    cs_down();
  endtask

  task automatic prog(input logic [1:0] op, input logic [5:0] f, input logic [15:0] d,
                      input bit with_data, input int nbits);
    logic s;
    cs_up();
    send_hdr(op, f, s);
    if (with_data) for (int k = 0; k < nbits; k++) sk_bit(d[15-k], s);
    cs_down();
    repeat (PROG + 4) @(negedge clk);
  endtask

  task automatic verify_all(input string tag);
    logic [15:0] w;
    for (int i = 0; i < 16; i++) begin
      read_word(4'(i), 0, w);
      check(w == model[i], tag, {16'd0, w}, {16'd0, model[i]});
    end
  endtask

  initial begin
    repeat (PROG * 4000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    logic s, last;
    int n;
    bit ok;
    for (int i = 0; i < 16; i++) model[i] = 16'hFFFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(do_o == 1'b0, "R1 reset ser_out", {31'd0, do_o}, 32'd0);
    verify_all("R1 reset word");

    // R10: latch clear, write ignored; an immediate read must be accepted (no busy)
    prog(2'b01, 6'h03, 16'h1234, 1'b1, 16);
    read_word(4'd3, 0, w);
    check(w == 16'hFFFF, "R10 write without enable", {16'd0, w}, 32'h0000FFFF);

    // R3/R5: set latch with don't-care low field bits
    prog(2'b00, 6'b11_1010, 16'h0, 1'b0, 0);
    for (int i = 0; i < 16; i++) begin
      model[i] = 16'((i * 16'h1357) ^ 16'hC0DE);
      prog(2'b01, {2'b00, 4'(i)}, model[i], 1'b1, 16);
    end
    verify_all("R7 write sweep");

    // R2: leading zeros before start bit
    read_word(4'd9, 3, w);
    check(w == model[9], "R2 leading zeros", {16'd0, w}, {16'd0, model[9]});

    // R8/R9: exact busy length
    cs_up();
    send_hdr(2'b01, 6'h05, s);
    for (int k = 0; k < 16; k++) sk_bit(k[0], s);
    model[5] = 16'h5555;
    @(negedge clk); cs = 1'b0; sk = 1'b0;
    @(negedge clk); cs = 1'b1;
    n = 0; ok = 1'b0;
    while (!ok && n < 4 * PROG) begin
      @(negedge clk); n++;
      if (do_o) ok = 1'b1;
    end
    check(n == PROG, "R8 busy length", n, PROG);
    check(ok, "R9 ready shown", {31'd0, ok}, 32'd1);
    repeat (3) @(negedge clk);
    check(do_o == 1'b1, "R9 ready held", {31'd0, do_o}, 32'd1);
    cs_down();
    read_word(4'd5, 0, w);
    check(w == model[5], "R8 write committed", {16'd0, w}, {16'd0, model[5]});

    // R12: start bits during busy ignored, status kept
    cs_up();
    send_hdr(2'b01, 6'h06, s);
    for (int k = 0; k < 16; k++) sk_bit(1'b0, s);
    model[6] = 16'h0000;
    @(negedge clk); cs = 1'b0; sk = 1'b0;
    @(negedge clk); cs = 1'b1;
    ok = 1'b1;
    for (int k = 0; k < 9; k++) begin
      sk_bit(k < 2, s);
      if (s !== 1'b0) ok = 1'b0;
    end
    check(ok, "R12 busy status during header", {31'd0, ok}, 32'd1);
    n = 0; last = 1'b0;
    while (!last && n < 2 * PROG) begin
      @(negedge clk); n++;
      last = do_o;
    end
    check(last == 1'b1, "R12 status kept after ignored start", {31'd0, last}, 32'd1);
    cs_down();
    read_word(4'd6, 0, w);
    check(w == 16'h0000, "R12 write done", {16'd0, w}, 32'd0);

    // R11: short write, and header aborted midway
    prog(2'b01, 6'h07, 16'h0000, 1'b1, 10);
    cs_up();
    sk_bit(1'b1, s); sk_bit(1'b0, s); sk_bit(1'b1, s);
    cs_down();
    read_word(4'd7, 0, w);
    check(w == model[7], "R11 abort", {16'd0, w}, {16'd0, model[7]});

    // R6: single erase
    prog(2'b11, 6'h02, 16'h0, 1'b0, 0);
    model[2] = 16'hFFFF;
    verify_all("R6 erase word");

    // R7: write-all, R3 low field bits ignored
    prog(2'b00, 6'b01_0101, 16'h5AA5, 1'b1, 16);
    for (int i = 0; i < 16; i++) model[i] = 16'h5AA5;
    verify_all("R7 write all");

    // R6: erase-all
    prog(2'b00, 6'b10_0000, 16'h0, 1'b0, 0);
    for (int i = 0; i < 16; i++) model[i] = 16'hFFFF;
    verify_all("R6 erase all");

    // R5: clear latch, writes blocked, reads still work
    prog(2'b01, 6'h04, 16'hBEEF, 1'b1, 16);
    model[4] = 16'hBEEF;
    prog(2'b00, 6'b00_0000, 16'h0, 1'b0, 0);
    prog(2'b01, 6'h04, 16'h0000, 1'b1, 16);
    prog(2'b00, 6'b01_0000, 16'h1111, 1'b1, 16);
    verify_all("R5 latch cleared");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule